// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block keeps the control state of a one-channel digital potentiometer. It holds an 8-bit volatile wiper code, an 8-bit non-volatile initial value (modelled as a register with a write-busy delay), and a one-bit volatile access selector. Its only output to the analog side is the 8-bit wiper code: code 00h puts the wiper nearest the low terminal, FFh nearest the high terminal, and the position moves monotonically in between.

A serial front end hands it decoded byte requests: a strobe, a read/write flag, a 2-bit address and a data byte. The block answers with an accept flag in the same cycle and, for accepted reads, a data byte with a valid pulse one cycle later. Address 0 reaches both the wiper code and the initial value. The access selector at address 2 decides which of them a read returns and whether a write also reaches the non-volatile copy. After reset the wiper sits at mid-scale (80h) until the stored initial value has been read, and then it takes that value.

Top module: `wpot_ctrl`

## Requirements
- R1: During and right after reset the wiper code is 80h, the power-up flag is high, the busy flag is low, the access selector reads 00h and the initial value equals the parameter NV_INIT (default 80h).
- R2: The power-up flag stays high for PU_CYCLES clock edges after reset release; at the edge where it drops the wiper code takes the stored initial value.
- R3: With the selector at 00h, an accepted read of address 0 returns the initial value; every accepted read raises rd_valid with rd_data on the following cycle.
- R4: With the selector at 00h, an accepted write to address 0 puts the byte into both the wiper code and the initial value, and raises the busy flag for NV_WR_CYCLES cycles starting the next cycle.
- R5: With the selector at 80h, an accepted read of address 0 returns the wiper code.
- R6: With the selector at 80h, an accepted write to address 0 changes only the wiper code; the initial value is untouched and the busy flag stays low.
- R7: Addresses 1 and 3 are reserved: writes to them change nothing, reads of them return 00h.
- R8: A write to address 2 stores 00h or 80h into the selector; any other value leaves it unchanged. A read of address 2 returns the selector byte.
- R9: req_accept is high only when req_valid is high and both the power-up flag and the busy flag are low; a refused request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the power-up sequence |
| req_valid | input | 1 | Request strobe from the serial front end |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 8 | Write data |
| req_accept | output | 1 | Request taken this cycle |
| rd_valid | output | 1 | Read data valid (one cycle after an accepted read) |
| rd_data | output | 8 | Read data |
| wiper_code | output | 8 | Wiper position to the resistor ladder |
| nv_busy | output | 1 | Non-volatile write in progress |
| pwrup_busy | output | 1 | Power-up load in progress |

## Verification
The bench goes after the shared address: a design that routed address 0 by the wrong selector value would return the wiper where the stored value is expected, or would let a wiper-only write leak into storage, which shows up when the selector is set back and the stored byte is read. It sends requests during power-up and during a storage write; a design that ignored the busy flags would accept them and corrupt the wiper. It writes reserved selector values and reserved addresses, where a design that decoded loosely would flip the selector or return non-zero data, and it uses a non-default initial value so that a missing power-up load leaves the wiper at 80h.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
    localparam int unsigned DW = 8;
    localparam int unsigned AW = 2;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    localparam addr_t ADDR_POT  = 2'd0;
    localparam addr_t ADDR_SEL  = 2'd2;
    localparam byte_t MID_SCALE = 8'h80;
    localparam byte_t SEL_NV    = 8'h00;
    localparam byte_t SEL_VOL   = 8'h80;

    typedef struct packed {
        byte_t wiper;
        logic  sel_vol;
        logic  rd_valid;
        byte_t rd_data;
    } ctrl_state_t;
endpackage

// File: rtl/wpot_nvm.sv
module wpot_nvm
    import wpot_pkg::*;
#(
    parameter byte_t       NV_INIT      = 8'h80,
    parameter int unsigned NV_WR_CYCLES = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wr_data,
    output byte_t nv_data,
    output logic  busy
);
    localparam int unsigned CW = $clog2(NV_WR_CYCLES + 1);

    typedef struct packed {
        byte_t         data;
        logic [CW-1:0] cnt;
    } nvm_state_t;

    nvm_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (wr_en) begin
            s_d.data = wr_data;
            s_d.cnt  = CW'(NV_WR_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.data <= NV_INIT;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign nv_data = s_q.data;
    assign busy    = (s_q.cnt != '0);

    // R4: a write only arrives while idle, and the count never exceeds its load value
    a_r4_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy);
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(NV_WR_CYCLES));
    a_r4_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (busy && nv_data == $past(wr_data)));
endmodule

// File: rtl/wpot_powerup.sv
module wpot_powerup
    import wpot_pkg::*;
#(
    parameter int unsigned PU_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy,
    output logic load
);
    localparam int unsigned CW = $clog2(PU_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } pu_state_t;

    pu_state_t s_q, s_d;
    logic      last;

    assign last = s_q.busy && (s_q.cnt == CW'(PU_CYCLES - 1));

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (last) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.busy <= 1'b1;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign load = last;

    // R2: once the sequence ends it never restarts without reset
    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);
    a_r2_load_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !busy);
endmodule

// File: rtl/wpot_ctrl.sv
module wpot_ctrl
    import wpot_pkg::*;
#(
    parameter byte_t       NV_INIT      = 8'h80,
    parameter int unsigned PU_CYCLES    = 4,
    parameter int unsigned NV_WR_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [1:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       req_accept,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic [7:0] wiper_code,
    output logic       nv_busy,
    output logic       pwrup_busy
);
    ctrl_state_t s_q, s_d;

    logic  pu_load;
    logic  nv_wr;
    byte_t nv_data;

    wpot_powerup #(
        .PU_CYCLES(PU_CYCLES)
    ) u_pu (
        .clk  (clk),
        .rst_n(rst_n),
        .busy (pwrup_busy),
        .load (pu_load)
    );

    wpot_nvm #(
        .NV_INIT     (NV_INIT),
        .NV_WR_CYCLES(NV_WR_CYCLES)
    ) u_nvm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (nv_wr),
        .wr_data(req_wdata),
        .nv_data(nv_data),
        .busy   (nv_busy)
    );

    assign req_accept = req_valid && !pwrup_busy && !nv_busy;

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        nv_wr        = 1'b0;

        if (pu_load) begin
            s_d.wiper = nv_data;
        end

        if (req_accept) begin
            if (req_write) begin
                if (req_addr == ADDR_POT) begin
                    s_d.wiper = req_wdata;
                    nv_wr     = !s_q.sel_vol;
                end else if (req_addr == ADDR_SEL) begin
                    if (req_wdata == SEL_NV) begin
                        s_d.sel_vol = 1'b0;
                    end else if (req_wdata == SEL_VOL) begin
                        s_d.sel_vol = 1'b1;
                    end
                end
            end else begin
                s_d.rd_valid = 1'b1;
                if (req_addr == ADDR_POT) begin
                    s_d.rd_data = s_q.sel_vol ? s_q.wiper : nv_data;
                end else if (req_addr == ADDR_SEL) begin
                    s_d.rd_data = s_q.sel_vol ? SEL_VOL : SEL_NV;
                end else begin
                    s_d.rd_data = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.wiper    <= MID_SCALE;
            s_q.sel_vol  <= 1'b0;
            s_q.rd_valid <= 1'b0;
            s_q.rd_data  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wiper_code = s_q.wiper;
    assign rd_valid   = s_q.rd_valid;
    assign rd_data    = s_q.rd_data;

    // R9: nothing is taken while either busy flag is up
    a_r9_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrup_busy || nv_busy) |-> !req_accept);
    // R2: wiper matches the stored value when power-up completes
    a_r2_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrup_busy) |-> (wiper_code == nv_data));
    // R3: read data appears exactly one cycle after an accepted read
    a_r3_rd_timing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_accept && !req_write));
    // R4: a shared write lands in both copies and starts the busy window
    a_r4_both_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_write && req_addr == ADDR_POT && !s_q.sel_vol)
        |=> (wiper_code == $past(req_wdata) && nv_data == $past(req_wdata) && nv_busy));
    // R6: a wiper-only write leaves storage alone
    a_r6_nv_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_write && req_addr == ADDR_POT && s_q.sel_vol)
        |=> ($stable(nv_data) && !nv_busy && wiper_code == $past(req_wdata)));
    // R7: reserved writes change nothing
    a_r7_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_write && req_addr[0])
        |=> ($stable(wiper_code) && $stable(nv_data) && $stable(s_q.sel_vol)));
    // R8: reserved selector values are dropped
    a_r8_sel_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_write && req_addr == ADDR_SEL
         && req_wdata != SEL_NV && req_wdata != SEL_VOL) |=> $stable(s_q.sel_vol));
endmodule

// File: tb/wpot_ctrl_test.sv
module wpot_ctrl_test;
    localparam time         CLK_HALF = 10ns;
    localparam logic [7:0]  T_INIT   = 8'h5A;
    localparam int unsigned T_PU     = 4;
    localparam int unsigned T_NVW    = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_accept, rd_valid, nv_busy, pwrup_busy;
    logic [7:0] rd_data, wiper_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state
    logic [7:0] m_wiper, m_nv, m_rdd;
    logic       m_sel, m_pub, m_rdv;
    int         m_pucnt, m_nvcnt;
    string      m_rdtag;

    always #CLK_HALF clk = ~clk;

    wpot_ctrl #(
        .NV_INIT     (T_INIT),
        .PU_CYCLES   (T_PU),
        .NV_WR_CYCLES(T_NVW)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_accept(req_accept),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .wiper_code(wiper_code),
        .nv_busy   (nv_busy),
        .pwrup_busy(pwrup_busy)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_accept();
        return req_valid && !m_pub && (m_nvcnt == 0);
    endfunction

    // model update at each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wiper = 8'h80; m_nv = T_INIT; m_sel = 1'b0;
            m_pub = 1'b1; m_pucnt = 0; m_nvcnt = 0;
            m_rdv = 1'b0; m_rdd = 8'h00; m_rdtag = "R3";
        end else begin
            bit acc;
            acc   = m_accept();
            m_rdv = 1'b0;
            if (m_pub) begin
                if (m_pucnt == T_PU - 1) begin
                    m_pub = 1'b0;
                    m_wiper = m_nv;
                end else begin
                    m_pucnt++;
                end
            end
            if (m_nvcnt != 0) m_nvcnt--;
            if (acc) begin
                if (req_write) begin
                    if (req_addr == 2'd0) begin
                        m_wiper = req_wdata;
                        if (!m_sel) begin
                            m_nv = req_wdata;
                            m_nvcnt = T_NVW;
                        end
                    end else if (req_addr == 2'd2) begin
                        if (req_wdata == 8'h00) m_sel = 1'b0;
                        else if (req_wdata == 8'h80) m_sel = 1'b1;
                    end
                end else begin
                    m_rdv = 1'b1;
                    case (req_addr)
                        2'd0: begin m_rdd = m_sel ? m_wiper : m_nv; m_rdtag = m_sel ? "R5" : "R3"; end
                        2'd2: begin m_rdd = m_sel ? 8'h80 : 8'h00; m_rdtag = "R8"; end
                        default: begin m_rdd = 8'h00; m_rdtag = "R7"; end
                    endcase
                end
            end
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(wiper_code == m_wiper, "R2", "wiper_code", wiper_code, m_wiper);
            check(pwrup_busy == m_pub, "R2", "pwrup_busy", 8'(pwrup_busy), 8'(m_pub));
            check(nv_busy == (m_nvcnt != 0), "R4", "nv_busy", 8'(nv_busy), 8'(m_nvcnt != 0));
            check(req_accept == m_accept(), "R9", "req_accept", 8'(req_accept), 8'(m_accept()));
            check(rd_valid == m_rdv, "R3", "rd_valid", 8'(rd_valid), 8'(m_rdv));
            if (m_rdv) check(rd_data == m_rdd, m_rdtag, "rd_data", rd_data, m_rdd);
        end
    end

    task automatic drive(input bit wr, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #2;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); #2;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        check(rd_valid && rd_data == exp, tag, "read", rd_data, exp);
        #2 req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (nv_busy || pwrup_busy) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(wiper_code == 8'h80, "R1", "wiper after reset", wiper_code, 8'h80);
        check(pwrup_busy == 1'b1, "R1", "pwrup_busy after reset", 8'(pwrup_busy), 8'h01);
        check(nv_busy == 1'b0, "R1", "nv_busy after reset", 8'(nv_busy), 8'h00);
        // R9: request during power-up is refused
        drive(1'b1, 2'd0, 8'hEE);
        wait_idle();
        // R2: wiper now holds the stored value
        check(wiper_code == T_INIT, "R2", "wiper after load", wiper_code, T_INIT);
        rd_expect(2'd2, 8'h00, "R1");
        rd_expect(2'd0, T_INIT, "R1");

        // R4: shared write, then a refused write while busy (R9)
        drive(1'b1, 2'd0, 8'h33);
        drive(1'b1, 2'd0, 8'h99);
        check(wiper_code == 8'h33, "R9", "wiper after refused write", wiper_code, 8'h33);
        wait_idle();
        rd_expect(2'd0, 8'h33, "R4");

        // R8 / R5 / R6
        drive(1'b1, 2'd2, 8'h80);
        rd_expect(2'd2, 8'h80, "R8");
        rd_expect(2'd0, 8'h33, "R5");
        drive(1'b1, 2'd0, 8'hC7);
        check(nv_busy == 1'b0, "R6", "no busy on wiper-only write", 8'(nv_busy), 8'h00);
        check(wiper_code == 8'hC7, "R6", "wiper-only write", wiper_code, 8'hC7);
        rd_expect(2'd0, 8'hC7, "R5");
        drive(1'b1, 2'd2, 8'h55);
        rd_expect(2'd2, 8'h80, "R8");
        drive(1'b1, 2'd2, 8'h01);
        rd_expect(2'd2, 8'h80, "R8");
        drive(1'b1, 2'd2, 8'h00);
        rd_expect(2'd0, 8'h33, "R6");

        // R7: reserved addresses
        drive(1'b1, 2'd1, 8'hFF);
        drive(1'b1, 2'd3, 8'h80);
        check(wiper_code == 8'hC7, "R7", "wiper after reserved writes", wiper_code, 8'hC7);
        rd_expect(2'd1, 8'h00, "R7");
        rd_expect(2'd3, 8'h00, "R7");
        rd_expect(2'd2, 8'h00, "R7");
        rd_expect(2'd0, 8'h33, "R7");

        // R4: end-of-scale codes
        drive(1'b1, 2'd0, 8'h00);
        wait_idle();
        check(wiper_code == 8'h00, "R4", "wiper at low end", wiper_code, 8'h00);
        drive(1'b1, 2'd0, 8'hFF);
        wait_idle();
        check(wiper_code == 8'hFF, "R4", "wiper at high end", wiper_code, 8'hFF);
        rd_expect(2'd0, 8'hFF, "R3");

        // back-to-back reads with selector switched (R5)
        drive(1'b1, 2'd2, 8'h80);
        drive(1'b1, 2'd0, 8'h10);
        rd_expect(2'd0, 8'h10, "R5");
        drive(1'b1, 2'd2, 8'h00);
        rd_expect(2'd0, 8'hFF, "R3");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule